// File: doc/BRIEF.md
# SDRAM Write Burst Sequencer

This block sits on the controller side of a 32-bit SDRAM channel. It turns host write requests into WRITE commands and the data words that go with them. A request names a bank, a starting column, a burst-length code and an auto-precharge flag. The data port supplies one word per cycle. The word presented in the cycle a request is accepted becomes the first beat of that burst.

All pin outputs come from registers. The WRITE command and its first data word leave the block together, one clock after the request is accepted. Each later word follows on the next rising edge. Any accepted request ends the burst in flight, to any bank, with no idle cycle between the two bursts.

A full-page burst runs for as long as the host keeps the data-valid input high. It ends with a burst-terminate command. Row activation, refresh and the read path are handled elsewhere, and the target row is already open.

The state machine has four states:
- IDLE drives NOP and releases the bus.
- CMD drives WRITE and the first beat.
- BEAT drives NOP and a further beat.
- STOP drives burst-terminate and releases the bus.

It has five transitions:
- *accept* goes from any state to CMD when a request is taken.
- *continue* goes from CMD or BEAT to BEAT.
- *finish* goes from CMD or BEAT to IDLE when a fixed burst is exhausted.
- *terminate* goes from CMD or BEAT to STOP when a full-page burst loses data-valid.
- *settle* goes from STOP to IDLE.

Top module: `sdram_wr_seq`

## Requirements
- R1: During and after reset, with no request, the command pins (cs_n, ras_n, cas_n, we_n) read 0,1,1,1 (NOP), the data output enable is 0 and the byte mask is 4'hF.
- R2: One cycle after a request is accepted, the command pins read 0,1,0,0 (WRITE). In that same cycle the following hold:
  - sd_addr[7:0] holds the column.
  - sd_addr[10] holds the auto-precharge flag.
  - All other address bits are 0.
  - sd_ba holds the bank.
  - The data output enable is 1.
  - sd_dq carries the wr_data value presented with the request.
- R3: Length code 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4 and 3'b011 gives 8. Codes 3'b100 to 3'b110 give 1 beat. Beats after the first come in consecutive cycles with NOP on the command pins, and each carries the wr_data value of the previous cycle.
- R4: In the cycle after the last beat of a fixed-length burst with no new request, the output enable is 0 and the command is NOP. Data presented then is ignored.
- R5: A request accepted while a burst is running produces WRITE with the new bank, column and data in the very next cycle, for any bank and at any offset into the running burst. The earlier burst then stops.
- R6: Length code 3'b111 (full page) keeps producing one beat per cycle while wr_valid is high, without limit, including beyond 256 beats.
- R7: When wr_valid is low during a full-page burst, the next cycle drives 0,1,1,0 (burst terminate) with the output enable at 0. The cycle after that drives NOP.
- R8: req_ready is high in every cycle after reset, including during bursts.
- R9: The byte mask is 4'h0 whenever the output enable is 1 and 4'hF whenever it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_bank | input | 2 | Target bank |
| req_col | input | 8 | Starting column |
| req_len | input | 3 | Burst-length code |
| req_ap | input | 1 | Auto precharge at burst end |
| wr_valid | input | 1 | Data present; holds a full-page burst open |
| wr_data | input | 32 | Write data word |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 12 | Address pins |
| sd_ba | output | 2 | Bank pins |
| sd_dq | output | 32 | Data bus output value |
| sd_dq_oe | output | 1 | Data bus output enable |
| sd_dqm | output | 4 | Byte mask |

## Verification
A sweep runs every length code against every bank and both auto-precharge values. It separates the beat counts of the four fixed lengths from the reserved codes, and shows that address and flag placement hold for every combination. A second sweep truncates an 8-beat burst at each offset from 1 to 7 with a request to a changing bank. This shows that the new WRITE and its data take over in the next cycle, with no gap and no leftover beat. Requests issued every cycle, to both the same bank and different banks, show full-rate chaining. A 300-beat full-page burst shows the absence of a 256-beat limit and the terminate-then-NOP ending, and a second full-page burst cut by a fixed request shows that page mode is cleared on takeover.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_BEAT,
        ST_STOP
    } wr_state_t;

    localparam logic [2:0] LEN_1    = 3'b000;
    localparam logic [2:0] LEN_2    = 3'b001;
    localparam logic [2:0] LEN_4    = 3'b010;
    localparam logic [2:0] LEN_8    = 3'b011;
    localparam logic [2:0] LEN_PAGE = 3'b111;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sd_cmd_t CMD_WRITE = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
    localparam sd_cmd_t CMD_TERM  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};

endpackage

// File: rtl/sdram_wr_fsm.sv
module sdram_wr_fsm
    import sdram_wr_pkg::*;
#(
    parameter int MAX_BURST = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [2:0] req_len,
    input  logic       wr_valid,
    output logic       req_ready,
    output wr_state_t  state,
    output logic       load,
    output logic       take
);

    localparam int CNT_W = $clog2(MAX_BURST);

    wr_state_t        st_q, st_d;
    logic [CNT_W-1:0] left_q, left_d;
    logic             page_q, page_d;
    logic             ready_q;
    logic             fire;

    assign fire      = req_valid && ready_q;
    assign req_ready = ready_q;
    assign state     = st_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            left_q  <= '0;
            page_q  <= 1'b0;
            ready_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            left_q  <= left_d;
            page_q  <= page_d;
            ready_q <= 1'b1;
        end
    end

    // next-state logic: accept has priority over every other transition
    always_comb begin
        st_d   = ST_IDLE;
        left_d = left_q;
        page_d = page_q;
        load   = 1'b0;
        take   = 1'b0;
        if (fire) begin
            // accept
            st_d   = ST_CMD;
            load   = 1'b1;
            take   = 1'b1;
            page_d = (req_len == LEN_PAGE);
            unique case (req_len)
                LEN_2:   left_d = CNT_W'(MAX_BURST / 4 - 1);
                LEN_4:   left_d = CNT_W'(MAX_BURST / 2 - 1);
                LEN_8:   left_d = CNT_W'(MAX_BURST - 1);
                default: left_d = '0;
            endcase
        end else begin
            unique case (st_q)
                ST_CMD, ST_BEAT: begin
                    if (page_q) begin
                        if (wr_valid) begin
                            st_d = ST_BEAT;          // continue
                            take = 1'b1;
                        end else begin
                            st_d   = ST_STOP;        // terminate
                            page_d = 1'b0;
                        end
                    end else if (left_q != '0) begin
                        st_d   = ST_BEAT;            // continue
                        take   = 1'b1;
                        left_d = left_q - CNT_W'(1);
                    end else begin
                        st_d = ST_IDLE;              // finish
                    end
                end
                ST_STOP: st_d = ST_IDLE;             // settle
                ST_IDLE: st_d = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sdram_wr_dp.sv
module sdram_wr_dp #(
    parameter int DATA_W = 32,
    parameter int COL_W  = 8,
    parameter int BANK_W = 2,
    parameter int ADDR_W = 12,
    parameter int AP_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              take,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_ap,
    input  logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] addr_q,
    output logic [BANK_W-1:0] bank_q,
    output logic [DATA_W-1:0] data_q
);

    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        addr_d                = '0;
        addr_d[COL_W-1:0]     = req_col;
        addr_d[AP_BIT]        = req_ap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            bank_q <= '0;
            data_q <= '0;
        end else begin
            if (load) begin
                addr_q <= addr_d;
                bank_q <= req_bank;
            end
            if (take) begin
                data_q <= wr_data;
            end
        end
    end

endmodule

// File: rtl/sdram_wr_pins.sv
module sdram_wr_pins
    import sdram_wr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BANK_W = 2,
    parameter int ADDR_W = 12
) (
    input  wr_state_t           state,
    input  logic [ADDR_W-1:0]   addr_q,
    input  logic [BANK_W-1:0]   bank_q,
    input  logic [DATA_W-1:0]   data_q,
    output sd_cmd_t             cmd,
    output logic [ADDR_W-1:0]   sd_addr,
    output logic [BANK_W-1:0]   sd_ba,
    output logic [DATA_W-1:0]   sd_dq,
    output logic                sd_dq_oe,
    output logic [DATA_W/8-1:0] sd_dqm
);

    // output process: pin values are a pure function of the registered state
    always_comb begin
        cmd      = CMD_NOP;
        sd_addr  = '0;
        sd_ba    = '0;
        sd_dq    = '0;
        sd_dq_oe = 1'b0;
        sd_dqm   = '1;
        unique case (state)
            ST_CMD: begin
                cmd      = CMD_WRITE;
                sd_addr  = addr_q;
                sd_ba    = bank_q;
                sd_dq    = data_q;
                sd_dq_oe = 1'b1;
                sd_dqm   = '0;
            end
            ST_BEAT: begin
                sd_dq    = data_q;
                sd_dq_oe = 1'b1;
                sd_dqm   = '0;
            end
            ST_STOP: cmd = CMD_TERM;
            ST_IDLE: cmd = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq
    import sdram_wr_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int COL_W     = 8,
    parameter int BANK_W    = 2,
    parameter int ADDR_W    = 12,
    parameter int AP_BIT    = 10,
    parameter int MAX_BURST = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [BANK_W-1:0]   req_bank,
    input  logic [COL_W-1:0]    req_col,
    input  logic [2:0]          req_len,
    input  logic                req_ap,
    input  logic                wr_valid,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                sd_cs_n,
    output logic                sd_ras_n,
    output logic                sd_cas_n,
    output logic                sd_we_n,
    output logic [ADDR_W-1:0]   sd_addr,
    output logic [BANK_W-1:0]   sd_ba,
    output logic [DATA_W-1:0]   sd_dq,
    output logic                sd_dq_oe,
    output logic [DATA_W/8-1:0] sd_dqm
);

    localparam int DQM_W = DATA_W / 8;

    wr_state_t         state;
    logic              load, take;
    logic [ADDR_W-1:0] addr_q;
    logic [BANK_W-1:0] bank_q;
    logic [DATA_W-1:0] data_q;
    sd_cmd_t           cmd;

    sdram_wr_fsm #(.MAX_BURST(MAX_BURST)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_len   (req_len),
        .wr_valid  (wr_valid),
        .req_ready (req_ready),
        .state     (state),
        .load      (load),
        .take      (take)
    );

    sdram_wr_dp #(
        .DATA_W (DATA_W),
        .COL_W  (COL_W),
        .BANK_W (BANK_W),
        .ADDR_W (ADDR_W),
        .AP_BIT (AP_BIT)
    ) i_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .take     (take),
        .req_bank (req_bank),
        .req_col  (req_col),
        .req_ap   (req_ap),
        .wr_data  (wr_data),
        .addr_q   (addr_q),
        .bank_q   (bank_q),
        .data_q   (data_q)
    );

    sdram_wr_pins #(
        .DATA_W (DATA_W),
        .BANK_W (BANK_W),
        .ADDR_W (ADDR_W)
    ) i_pins (
        .state    (state),
        .addr_q   (addr_q),
        .bank_q   (bank_q),
        .data_q   (data_q),
        .cmd      (cmd),
        .sd_addr  (sd_addr),
        .sd_ba    (sd_ba),
        .sd_dq    (sd_dq),
        .sd_dq_oe (sd_dq_oe),
        .sd_dqm   (sd_dqm)
    );

    assign sd_cs_n  = cmd.cs_n;
    assign sd_ras_n = cmd.ras_n;
    assign sd_cas_n = cmd.cas_n;
    assign sd_we_n  = cmd.we_n;

endmodule

// File: rtl/sdram_wr_seq_chk.sv
module sdram_wr_seq_chk #(
    parameter int DQM_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             sd_cs_n,
    input logic             sd_ras_n,
    input logic             sd_cas_n,
    input logic             sd_we_n,
    input logic             sd_dq_oe,
    input logic [DQM_W-1:0] sd_dqm
);

    logic [3:0] pins;
    assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    // R1: only NOP, WRITE or burst terminate ever appear
    a_r1_cmd_set: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0111) || (pins == 4'b0100) || (pins == 4'b0110));

    // R2: a WRITE always carries its first beat
    a_r2_write_drives_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0100) |-> sd_dq_oe);

    // R5: every accepted request is followed by WRITE
    a_r5_accept_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (pins == 4'b0100));

    // R7: terminate only directly after a driven beat, with the bus released
    a_r7_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0110) |-> (!sd_dq_oe && $past(sd_dq_oe)));

    // R8: ready stays high once out of reset
    a_r8_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> req_ready);

    // R9: byte mask follows the output enable
    a_r9_mask_on: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> (sd_dqm == '0));
    a_r9_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_dq_oe |-> (sd_dqm == '1));

endmodule

bind sdram_wr_seq sdram_wr_seq_chk #(.DQM_W(DQM_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_dq_oe  (sd_dq_oe),
    .sd_dqm    (sd_dqm)
);

// File: tb/test_sdram_wr_seq.sv
module test_sdram_wr_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_bank = '0;
    logic [7:0]  req_col = '0;
    logic [2:0]  req_len = '0;
    logic        req_ap = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [11:0] sd_addr;
    logic [1:0]  sd_ba;
    logic [31:0] sd_dq;
    logic        sd_dq_oe;
    logic [3:0]  sd_dqm;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sdram_wr_seq i_sdram_wr_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_col(req_col), .req_len(req_len), .req_ap(req_ap),
        .wr_valid(wr_valid), .wr_data(wr_data),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_dq(sd_dq), .sd_dq_oe(sd_dq_oe), .sd_dqm(sd_dqm)
    );

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] pins();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    function automatic int nbeats(logic [2:0] l);
        case (l)
            3'b001:  return 2;
            3'b010:  return 4;
            3'b011:  return 8;
            default: return 1;
        endcase
    endfunction

    // drive at the falling edge, let one rising edge pass, return at the next falling edge
    task automatic step(bit rv, logic [1:0] b, logic [7:0] c, logic [2:0] l, bit ap,
                        bit wv, logic [31:0] d);
        req_valid = rv; req_bank = b; req_col = c; req_len = l; req_ap = ap;
        wr_valid = wv; wr_data = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_write(string tag, logic [1:0] b, logic [7:0] c, bit ap, logic [31:0] d);
        logic [11:0] ea;
        ea = {1'b0, ap, 2'b00, c};
        chk(tag, "write cmd", 64'(pins()), 64'(4'b0100));
        chk(tag, "write addr", 64'(sd_addr), 64'(ea));
        chk(tag, "write bank", 64'(sd_ba), 64'(b));
        chk(tag, "write data", 64'(sd_dq), 64'(d));
        chk(tag, "write oe", 64'(sd_dq_oe), 64'(1'b1));
        chk("R9", "write mask", 64'(sd_dqm), 64'(4'h0));
    endtask

    task automatic chk_beat(string tag, logic [31:0] d);
        chk(tag, "beat cmd", 64'(pins()), 64'(4'b0111));
        chk(tag, "beat data", 64'(sd_dq), 64'(d));
        chk(tag, "beat oe", 64'(sd_dq_oe), 64'(1'b1));
        chk("R9", "beat mask", 64'(sd_dqm), 64'(4'h0));
        chk("R8", "ready in burst", 64'(req_ready), 64'(1'b1));
    endtask

    task automatic chk_idle(string tag);
        chk(tag, "idle cmd", 64'(pins()), 64'(4'b0111));
        chk(tag, "idle oe", 64'(sd_dq_oe), 64'(1'b0));
        chk("R9", "idle mask", 64'(sd_dqm), 64'(4'hF));
    endtask

    function automatic logic [31:0] pat(int a, int b, int c);
        return 32'hC0000000 ^ 32'(a * 65536 + b * 256 + c);
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_idle("R1");
        chk("R1", "ready in reset", 64'(req_ready), 64'(1'b0));
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk_idle("R1");
        chk("R8", "ready after reset", 64'(req_ready), 64'(1'b1));

        // sweep: length codes x banks x auto-precharge
        for (int l = 0; l < 7; l++) begin
            for (int b = 0; b < 4; b++) begin
                for (int ap = 0; ap < 2; ap++) begin
                    logic [7:0] c;
                    int n;
                    c = 8'((l * 37 + b * 61 + ap * 100) % 256);
                    n = nbeats(3'(l));
                    step(1, 2'(b), c, 3'(l), ap[0], 1, pat(l, b, 0));
                    chk_write("R2", 2'(b), c, ap[0], pat(l, b, 0));
                    for (int j = 1; j < n; j++) begin
                        step(0, 0, 0, 0, 0, 1, pat(l, b, j));
                        chk_beat("R3", pat(l, b, j));
                    end
                    step(0, 0, 0, 0, 0, 1, 32'hDEADBEEF);
                    chk_idle("R4");
                    chk("R3", "no extra beat", 64'(sd_dq_oe), 64'(1'b0));
                end
            end
        end

        // truncation of an 8-beat burst at every offset
        for (int k = 1; k < 8; k++) begin
            step(1, 2'(3 - k % 4), 8'h10, 3'b011, 0, 1, pat(9, k, 0));
            chk_write("R5", 2'(3 - k % 4), 8'h10, 1'b0, pat(9, k, 0));
            for (int j = 1; j < k; j++) begin
                step(0, 0, 0, 0, 0, 1, pat(9, k, j));
                chk_beat("R5", pat(9, k, j));
            end
            step(1, 2'(k % 4), 8'(k * 3), 3'b001, 1, 1, pat(10, k, 0));
            chk_write("R5", 2'(k % 4), 8'(k * 3), 1'b1, pat(10, k, 0));
            step(0, 0, 0, 0, 0, 1, pat(10, k, 1));
            chk_beat("R5", pat(10, k, 1));
            step(0, 0, 0, 0, 0, 1, 32'h0BADF00D);
            chk_idle("R4");
        end

        // back-to-back single writes every cycle, different and same bank
        for (int i = 0; i < 8; i++) begin
            logic [1:0] bb;
            bb = (i < 4) ? 2'(i) : 2'd2;
            step(1, bb, 8'(i * 29), 3'b000, i[0], 1, pat(11, i, 0));
            chk_write("R5", bb, 8'(i * 29), i[0], pat(11, i, 0));
        end
        step(0, 0, 0, 0, 0, 0, 0);
        chk_idle("R4");

        // long full-page burst
        step(1, 2'd1, 8'hF0, 3'b111, 0, 1, pat(12, 0, 0));
        chk_write("R6", 2'd1, 8'hF0, 1'b0, pat(12, 0, 0));
        for (int j = 1; j < 300; j++) begin
            step(0, 0, 0, 0, 0, 1, pat(12, j / 256, j % 256));
            chk_beat("R6", pat(12, j / 256, j % 256));
        end
        step(0, 0, 0, 0, 0, 0, 32'h12345678);
        chk("R7", "terminate cmd", 64'(pins()), 64'(4'b0110));
        chk("R7", "terminate oe", 64'(sd_dq_oe), 64'(1'b0));
        chk("R9", "terminate mask", 64'(sd_dqm), 64'(4'hF));
        step(0, 0, 0, 0, 0, 0, 0);
        chk_idle("R7");

        // full-page cut by a fixed single write
        step(1, 2'd3, 8'h05, 3'b111, 0, 1, pat(13, 0, 0));
        chk_write("R6", 2'd3, 8'h05, 1'b0, pat(13, 0, 0));
        for (int j = 1; j < 6; j++) begin
            step(0, 0, 0, 0, 0, 1, pat(13, 0, j));
            chk_beat("R6", pat(13, 0, j));
        end
        step(1, 2'd0, 8'hAA, 3'b000, 1, 1, pat(14, 0, 0));
        chk_write("R5", 2'd0, 8'hAA, 1'b1, pat(14, 0, 0));
        step(0, 0, 0, 0, 0, 1, 32'hFFFF0000);
        chk_idle("R4");
        step(0, 0, 0, 0, 0, 0, 0);
        chk_idle("R1");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule